// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between the clock sources of a board-level clock generator and its output pins. It gates the CPU clocks, a bank of stoppable PCI clocks, one free-running PCI clock and a set of fixed-frequency clocks. Three active-low control pins drive the gating: CPU stop, PCI stop and power down. The pins are asynchronous. Each one passes through a two-flop synchronizer clocked by the free-running PCI clock, which also clocks the sequencer.

Every gate changes its enable only while its source clock is low. A stopped output therefore rests low, and the first high pulse after a restart is a full half period.

Power down takes precedence over both stop pins and runs an ordered sequence:
- All outputs are gated off.
- After a hold interval, the VCO enable drops.
- After a second hold interval, the oscillator enable drops.

Wake-up reverses the order:
- The oscillator enable rises first.
- After a settle count, the VCO enable rises.
- After a lock-wait count, the clocks are released.

The design assumes three things:
- The sequencer clock keeps running from an always-on source during power down.
- The CPU source is phase-aligned to the PCI clock.
- The hold interval covers the resynchronization delay of the slowest fixed clock.

Top module: `clkstop_ctl`

## Requirements
- R1: A level change on the CPU stop pin takes effect through two sequencer-clock edges. The last CPU output rising edge before a stop coincides with the second PCI clock rising edge after the pin falls. After a release, the first CPU rising edge follows that second edge by one CPU clock period.
- R2: While CPU stop is low (0), every CPU output is held low with no rising edge. The free-running PCI, gated PCI and fixed outputs keep toggling.
- R3: No gated output ever produces a high pulse shorter than half its source period, across stops, restarts and power sequences.
- R4: While PCI stop is low (0), every gated PCI output is held low. The free-running PCI output keeps toggling at its source rate.
- R5: After the power-down pin falls, all clocks are gated off on the third sequencer edge. The VCO enable falls HOLD_CYC edges later, and the VCO enable never falls while the clocks are enabled.
- R6: In power down, the CPU stop and PCI stop pins have no effect. All outputs stay low, and both enables stay as the sequence left them.
- R7: After the power-down pin rises, the oscillator enable rises on the third sequencer edge. The VCO enable rises OSC_SETTLE edges later, and the clocks are released LOCK_WAIT edges after that. With the default counts, the whole wake-up is far below 3 ms.
- R8: If power down is asserted again during the settle or lock wait, the VCO enable drops on the third edge. The oscillator enable drops HOLD_CYC edges later, and no clock is released in between.
- R9: Out of reset with all pins high, both enables are high and all clocks run.
- R10: The oscillator enable is never low while the VCO enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running PCI source clock; it also clocks the sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_clk_i | input | 1 | CPU source clock, phase-aligned to clk |
| fix_clk_i | input | N_FIX | Fixed-frequency source clocks |
| cpu_stop_n | input | 1 | Asynchronous CPU clock stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI clock stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power down, active low |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| pci_free_o | output | 1 | Free-running PCI clock, gated only by power down |
| fix_clk_o | output | N_FIX | Gated fixed-frequency clocks |
| vco_en_o | output | 1 | VCO enable |
| osc_en_o | output | 1 | Crystal oscillator enable |

## Verification
The hardest state to reach is a power-down request that arrives during the wake-up lock wait. The VCO is already on at that point, but no clock has been released yet. The stimulus first completes a full power-down and then releases the pin. It counts sequencer edges until the VCO enable has just risen and drives the pin low again inside the lock window. It then checks that the enables unwind in order and that no output edge appears.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock stop / power-down sequencer.
package clkstop_pkg;
    // Power sequencer states, in the order a full down/up cycle visits them.
    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAIN,
        ST_VCO_OFF,
        ST_OFF,
        ST_OSC_UP,
        ST_LOCK
    } pwr_state_t;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for active-low control pins.
// Assumes the inputs are asynchronous to clk. It resets to all ones, which is
// the inactive level of every pin.
module clkstop_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] pins_s
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw pins through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= pins_i;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign pins_s = stg[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// Low-state clock gate. The enable is captured on the falling edge of the
// source clock, so the output can only stop or start while the source is low.
// That makes it stop low and restart with a full high phase.
// RESYNC=1 adds two rising-edge flops for sources unrelated to the enable's
// clock. RESYNC=0 assumes the enable is launched phase-aligned to the source.
module clkstop_gate #(
    parameter bit RESYNC = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o
);
    logic en_dom;
    logic en_q;

    if (RESYNC) begin : g_resync
        logic [1:0] sh;
        // Bring the enable into the source domain.
        always_ff @(posedge src_clk) begin
            if (!rst_n) sh <= 2'b00;
            else        sh <= {sh[0], en_i};
        end
        assign en_dom = sh[1];
    end else begin : g_direct
        assign en_dom = en_i;
    end

    // Change the gate only while the source is low.
    always_ff @(negedge src_clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_dom;
    end

    assign gclk_o = src_clk & en_q;
endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
// Power sequencer and gate-enable decode.
// Down order: gate all clocks, wait HOLD_CYC, drop the VCO, wait HOLD_CYC, drop
// the oscillator. Up order: raise the oscillator, wait OSC_SETTLE, raise the
// VCO, wait LOCK_WAIT, release the clocks. A new request during wake-up unwinds
// through the VCO-off state. Inputs are already synchronized.
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int HOLD_CYC   = 8,
    parameter int OSC_SETTLE = 16,
    parameter int LOCK_WAIT  = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_s,
    input  logic cs_s,
    input  logic ps_s,
    output logic cpu_en_o,
    output logic pci_en_o,
    output logic free_en_o,
    output logic vco_en_o,
    output logic osc_en_o
);
    localparam int MAX_A = (HOLD_CYC > OSC_SETTLE) ? HOLD_CYC : OSC_SETTLE;
    localparam int MAXC  = (MAX_A > LOCK_WAIT) ? MAX_A : LOCK_WAIT;
    localparam int CW    = $clog2(MAXC + 1);

    pwr_state_t    state, state_nxt;
    logic [CW-1:0] cnt, last;
    logic          done;

    // Select the terminal count of the current timed state.
    always_comb begin
        case (state)
            ST_DRAIN, ST_VCO_OFF: last = CW'(HOLD_CYC - 1);
            ST_OSC_UP:            last = CW'(OSC_SETTLE - 1);
            ST_LOCK:              last = CW'(LOCK_WAIT - 1);
            default:              last = '0;
        endcase
    end
    assign done = (cnt == last);

    // Next-state decode; power down overrides everything.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_RUN:     if (!pd_s) state_nxt = ST_DRAIN;
            ST_DRAIN:   if (done)  state_nxt = ST_VCO_OFF;
            ST_VCO_OFF: if (done)  state_nxt = ST_OFF;
            ST_OFF:     if (pd_s)  state_nxt = ST_OSC_UP;
            ST_OSC_UP:  if (!pd_s) state_nxt = ST_VCO_OFF;
                        else if (done) state_nxt = ST_LOCK;
            ST_LOCK:    if (!pd_s) state_nxt = ST_VCO_OFF;
                        else if (done) state_nxt = ST_RUN;
            default:    state_nxt = ST_RUN;
        endcase
    end

    // State register and interval counter; the counter clears on every change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state || state == ST_RUN || state == ST_OFF)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // Enable decode from the state and the synchronized stop pins.
    assign free_en_o = (state == ST_RUN);
    assign cpu_en_o  = free_en_o & cs_s;
    assign pci_en_o  = free_en_o & ps_s;
    assign vco_en_o  = (state == ST_RUN) || (state == ST_DRAIN) || (state == ST_LOCK);
    assign osc_en_o  = (state != ST_OFF);

    assert_osc_covers_vco_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> !vco_en_o);
    assert_vco_after_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en_o) |-> $past(osc_en_o));
    assert_clocks_gated_before_vco_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en_o) |-> $past(!free_en_o));
    assert_pd_masks_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_s |=> (!cpu_en_o && !pci_en_o && !free_en_o));
    assert_wake_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !pd_s) |=> !vco_en_o);
endmodule

// File: rtl/clkstop_ctl.sv
`timescale 1ns/1ps
// Top of the clock stop / power-down controller. It synchronizes the three
// control pins to the free-running PCI clock, runs the power sequencer, and
// drives one low-state gate per output. Assumes cpu_clk_i is phase-aligned to
// clk and that clk keeps running during power down.
module clkstop_ctl #(
    parameter int N_CPU      = 2,
    parameter int N_PCI      = 5,
    parameter int N_FIX      = 2,
    parameter int SYNC_STG   = 2,
    parameter int HOLD_CYC   = 8,
    parameter int OSC_SETTLE = 16,
    parameter int LOCK_WAIT  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_clk_i,
    input  logic [N_FIX-1:0] fix_clk_i,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_PCI-1:0] pci_clk_o,
    output logic             pci_free_o,
    output logic [N_FIX-1:0] fix_clk_o,
    output logic             vco_en_o,
    output logic             osc_en_o
);
    logic [2:0] pins_s;
    logic       cpu_en, pci_en, free_en;

    clkstop_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
        .pins_s (pins_s)
    );

    clkstop_seq #(
        .HOLD_CYC   (HOLD_CYC),
        .OSC_SETTLE (OSC_SETTLE),
        .LOCK_WAIT  (LOCK_WAIT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_s      (pins_s[2]),
        .ps_s      (pins_s[1]),
        .cs_s      (pins_s[0]),
        .cpu_en_o  (cpu_en),
        .pci_en_o  (pci_en),
        .free_en_o (free_en),
        .vco_en_o  (vco_en_o),
        .osc_en_o  (osc_en_o)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        clkstop_gate #(.RESYNC(1'b0)) u_gate (
            .src_clk (cpu_clk_i), .rst_n (rst_n), .en_i (cpu_en), .gclk_o (cpu_clk_o[i]));
    end

    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
        clkstop_gate #(.RESYNC(1'b0)) u_gate (
            .src_clk (clk), .rst_n (rst_n), .en_i (pci_en), .gclk_o (pci_clk_o[i]));
    end

    clkstop_gate #(.RESYNC(1'b0)) u_free (
        .src_clk (clk), .rst_n (rst_n), .en_i (free_en), .gclk_o (pci_free_o));

    for (genvar i = 0; i < N_FIX; i++) begin : g_fix
        clkstop_gate #(.RESYNC(1'b1)) u_gate (
            .src_clk (fix_clk_i[i]), .rst_n (rst_n), .en_i (free_en), .gclk_o (fix_clk_o[i]));
    end
endmodule

// File: tb/tb_clkstop_ctl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario. Inputs change and outputs are sampled
// 0.5 ns after a rising edge of clk.
module tb_clkstop_ctl;
    localparam int HOLD = 8;
    localparam int OSC  = 16;
    localparam int LOCK = 32;

    logic       clk = 1'b0, rst_n = 1'b0, cpu_clk = 1'b1;
    logic [1:0] fix_clk = 2'b00;
    logic       cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [1:0] cpu_o;
    logic [4:0] pci_o;
    logic [1:0] fix_o;
    logic       free_o, vco_en, osc_en;

    always #2 clk = ~clk;           // 250 MHz sequencer / PCI source
    always #1 cpu_clk = ~cpu_clk;   // CPU source at twice the rate, aligned
    always #3 fix_clk[0] = ~fix_clk[0];
    always #5 fix_clk[1] = ~fix_clk[1];

    clkstop_ctl #(.HOLD_CYC(HOLD), .OSC_SETTLE(OSC), .LOCK_WAIT(LOCK)) dut (
        .clk (clk), .rst_n (rst_n), .cpu_clk_i (cpu_clk), .fix_clk_i (fix_clk),
        .cpu_stop_n (cpu_stop_n), .pci_stop_n (pci_stop_n), .pwr_dn_n (pwr_dn_n),
        .cpu_clk_o (cpu_o), .pci_clk_o (pci_o), .pci_free_o (free_o),
        .fix_clk_o (fix_o), .vco_en_o (vco_en), .osc_en_o (osc_en)
    );

    int  n_chk = 0, n_err = 0;
    int  n_cpu = 0, n_pci = 0, n_free = 0, n_fix = 0;
    int  runts = 0;
    bit  armed = 1'b0;
    realtime t_cpu = 0, t_pci = 0, t_free = 0, t_fix = 0;

    always @(posedge cpu_o[0]) begin n_cpu++;  t_cpu  = $realtime; end
    always @(posedge pci_o[0]) begin n_pci++;  t_pci  = $realtime; end
    always @(posedge free_o)   begin n_free++; t_free = $realtime; end
    always @(posedge fix_o[0]) begin n_fix++;  t_fix  = $realtime; end
    always @(negedge cpu_o[0]) if (armed && ($realtime - t_cpu)  < 0.9) runts++;
    always @(negedge pci_o[0]) if (armed && ($realtime - t_pci)  < 1.9) runts++;
    always @(negedge free_o)   if (armed && ($realtime - t_free) < 1.9) runts++;
    always @(negedge fix_o[0]) if (armed && ($realtime - t_fix)  < 2.9) runts++;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    task automatic clear_counts();
        n_cpu = 0; n_pci = 0; n_free = 0; n_fix = 0;
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input string what, input int act, input int lo);
        n_chk++;
        if (act < lo) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lo);
        end
    endtask

    // R9: reset state with all pins high.
    task automatic t_reset();
        rst_n = 1'b0;
        step(5);
        rst_n = 1'b1;
        step(4);
        armed = 1'b1;
        check_eq("R9", "osc_en after reset", int'(osc_en), 1);
        check_eq("R9", "vco_en after reset", int'(vco_en), 1);
        clear_counts();
        step(4);
        check_eq("R9", "cpu rises in 4 cycles", n_cpu, 8);
        check_eq("R9", "free pci rises in 4 cycles", n_free, 4);
        check_ge("R9", "fixed rises in 4 cycles", n_fix, 2);
    endtask

    // R1, R2: CPU stop latency and hold-low.
    task automatic t_cpu_stop();
        cpu_stop_n = 1'b0;
        clear_counts();
        step(2);
        check_eq("R1", "cpu rises until second edge", n_cpu, 4);
        clear_counts();
        step(4);
        check_eq("R2", "cpu rises while stopped", n_cpu, 0);
        check_eq("R2", "cpu level while stopped", int'(cpu_o), 0);
        check_eq("R2", "gated pci rises during cpu stop", n_pci, 4);
        check_eq("R2", "free pci rises during cpu stop", n_free, 4);
        check_ge("R2", "fixed rises during cpu stop", n_fix, 2);
    endtask

    // R1, R3: CPU restart latency and full first pulse.
    task automatic t_cpu_start();
        cpu_stop_n = 1'b1;
        clear_counts();
        step(2);
        check_eq("R1", "cpu rises before restart edge", n_cpu, 0);
        step(1);
        check_eq("R1", "cpu rises one cycle after restart", n_cpu, 2);
        check_eq("R3", "runt pulses after cpu restart", runts, 0);
    endtask

    // R4: PCI stop holds gated PCI low, free PCI runs.
    task automatic t_pci_stop();
        pci_stop_n = 1'b0;
        step(2);
        clear_counts();
        step(4);
        check_eq("R4", "gated pci rises while stopped", n_pci, 0);
        check_eq("R4", "gated pci level while stopped", int'(pci_o), 0);
        check_eq("R4", "free pci rises while pci stopped", n_free, 4);
        pci_stop_n = 1'b1;
        clear_counts();
        step(4);
        check_eq("R4", "gated pci rises after release", n_pci, 2);
    endtask

    // R5, R10: ordered power-down entry.
    task automatic t_pd_enter();
        pwr_dn_n = 1'b0;
        step(3);
        check_eq("R5", "vco_en at gating edge", int'(vco_en), 1);
        step(HOLD - 1);
        check_eq("R5", "vco_en before hold ends", int'(vco_en), 1);
        step(1);
        check_eq("R5", "vco_en after hold", int'(vco_en), 0);
        check_eq("R5", "osc_en while vco off", int'(osc_en), 1);
        clear_counts();
        step(HOLD - 1);
        check_eq("R5", "osc_en before second hold ends", int'(osc_en), 1);
        step(1);
        check_eq("R5", "osc_en after second hold", int'(osc_en), 0);
        check_eq("R10", "vco off when osc off", int'(vco_en), 0);
        check_eq("R5", "output rises after vco off", n_cpu + n_pci + n_free + n_fix, 0);
        check_eq("R5", "output levels in power down",
                 int'({cpu_o, pci_o, free_o, fix_o}), 0);
    endtask

    // R6: stop pins ignored in power down.
    task automatic t_pd_ignore();
        clear_counts();
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        step(3);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        step(6);
        check_eq("R6", "output rises with stop pins toggled", n_cpu + n_pci + n_free + n_fix, 0);
        check_eq("R6", "osc_en with stop pins toggled", int'(osc_en), 0);
        check_eq("R6", "vco_en with stop pins toggled", int'(vco_en), 0);
    endtask

    // R7: ordered wake-up.
    task automatic t_pd_exit();
        pwr_dn_n = 1'b1;
        step(2);
        check_eq("R7", "osc_en before third edge", int'(osc_en), 0);
        step(1);
        check_eq("R7", "osc_en at third edge", int'(osc_en), 1);
        check_eq("R7", "vco_en at third edge", int'(vco_en), 0);
        step(OSC - 1);
        check_eq("R7", "vco_en before settle ends", int'(vco_en), 0);
        step(1);
        check_eq("R7", "vco_en after settle", int'(vco_en), 1);
        clear_counts();
        step(LOCK);
        check_eq("R7", "cpu rises during lock wait", n_cpu, 0);
        step(2);
        check_eq("R7", "cpu rises after release", n_cpu, 4);
        check_eq("R3", "runt pulses after wake-up", runts, 0);
    endtask

    // R8: power down re-asserted inside the lock wait.
    task automatic t_abort();
        pwr_dn_n = 1'b0;
        step(3 + 2 * HOLD + 1);
        pwr_dn_n = 1'b1;
        step(3 + OSC);
        check_eq("R8", "vco_en in lock window", int'(vco_en), 1);
        clear_counts();
        pwr_dn_n = 1'b0;
        step(2);
        check_eq("R8", "vco_en before abort edge", int'(vco_en), 1);
        step(1);
        check_eq("R8", "vco_en after abort edge", int'(vco_en), 0);
        step(HOLD - 1);
        check_eq("R8", "osc_en before abort hold ends", int'(osc_en), 1);
        step(1);
        check_eq("R8", "osc_en after abort hold", int'(osc_en), 0);
        check_eq("R8", "output rises during abort", n_cpu + n_pci + n_free + n_fix, 0);
        pwr_dn_n = 1'b1;
        step(3 + OSC + LOCK + 4);
        check_ge("R8", "cpu running after recovery", n_cpu, 2);
        check_eq("R3", "runt pulses over whole run", runts, 0);
    endtask

    initial begin
        t_reset();
        t_cpu_stop();
        t_cpu_start();
        t_pci_stop();
        t_pd_enter();
        t_pd_ignore();
        t_pd_exit();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule